// File: doc/BRIEF.md
# Three-Band PWM Decoder and Non-Overlap Sequencer for a Half-Bridge

This block is the digital control core of a synchronous buck half-bridge gate driver. Two comparator flags sort the analog PWM level into three bands. One flag is set when the level is above the upper threshold and the other when it is above the lower threshold. A third flag gives the sign of the inductor current. The three flags are resynchronised and decoded into a turn-on request for each switch. In the high band the high-side switch is requested. In the low band the low-side switch is requested. In the middle band the high-side switch is off and the low-side switch follows the current sign, which gives diode emulation at light load.

Each request passes through a turn-on sequencer before it reaches a gate command. A switch is turned off as soon as its request drops. A switch is turned on only after the opposite command is low, the opposite switch reports that it is off, and a programmable delay has then run out. If the off report never arrives, a timeout lets the sequence go on and raises a sticky flag. A force-off input from the protection logic pulls both commands low at once, without waiting for a clock edge.

Top module: `hb_gate_sequencer`

## Requirements
- R1: With both band flags set (high band), the settled outputs are hs_gate_o=1 and ls_gate_o=0, whatever the current flag.
- R2: With both band flags clear (low band), the settled outputs are ls_gate_o=1 and hs_gate_o=0, whatever the current flag.
- R3: With pwm_above_hi_i=0 and pwm_above_lo_i=1 (middle band), hs_gate_o settles to 0, and ls_gate_o settles to the value of cur_pos_i (1 = positive current = on).
- R4: The invalid combination pwm_above_hi_i=1 with pwm_above_lo_i=0 behaves exactly like the middle band.
- R5: When the low-side off feedback is present, hs_gate_o rises exactly 2+DT_HS_CYC clock edges after the edge on which ls_gate_o fell.
- R6: When the high-side off feedback is present, ls_gate_o rises exactly 2+DT_LS_CYC clock edges after the edge on which hs_gate_o fell.
- R7: hs_gate_o and ls_gate_o are never high together.
- R8: While force_off_i is high, both gate outputs are low in the same cycle, with no clock edge needed.
- R9: If the opposite switch's off feedback stays low, the waiting side continues after FB_TMO_CYC cycles of waiting. The turn-on then comes 1+FB_TMO_CYC+DT edges after the opposite command fell, and fb_timeout_o goes high.
- R10: fb_timeout_o stays high until reset. Reset clears both gate outputs and fb_timeout_o at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_above_hi_i | input | 1 | PWM level is above the upper threshold |
| pwm_above_lo_i | input | 1 | PWM level is above the lower threshold |
| cur_pos_i | input | 1 | Inductor current sign, 1 = positive |
| hs_off_fb_i | input | 1 | High-side switch sensed off |
| ls_off_fb_i | input | 1 | Low-side switch sensed off |
| force_off_i | input | 1 | Protection force-off of both gates |
| hs_gate_o | output | 1 | High-side gate command |
| ls_gate_o | output | 1 | Low-side gate command |
| fb_timeout_o | output | 1 | Sticky flag: an off-feedback wait timed out |

## Verification
The bench builds the block with DT_HS_CYC=3, DT_LS_CYC=5 and FB_TMO_CYC=20. Because the two delays differ, a swap between the high-side and low-side timer shows up in the measured turn-on gaps of 5 and 7 edges. The short timeout makes the stuck-feedback path reachable in a few dozen cycles, with an expected gap of 24 edges. The bench models the off feedback as the inverse of each gate command, and it can hold either feedback stuck low.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    BAND_LOW  = 2'd0,
    BAND_MID  = 2'd1,
    BAND_HIGH = 2'd2
  } band_e;

  typedef enum logic [1:0] {
    SQ_OFF     = 2'd0,
    SQ_WAIT_FB = 2'd1,
    SQ_DELAY   = 2'd2,
    SQ_ON      = 2'd3
  } seq_e;
endpackage

// File: rtl/hb_rst_sync.sv
module hb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hb_band_decode.sv
module hb_band_decode
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_hi_i,
  input  logic above_lo_i,
  input  logic cur_pos_i,
  output logic req_hs_o,
  output logic req_ls_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  band_e           band;

  assign raw = {cur_pos_i, above_lo_i, above_hi_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] sr_q;
    logic [SYNC_STAGES-1:0] sr_d;

    always_comb sr_d = {sr_q[SYNC_STAGES-2:0], raw[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_d;
    end

    assign synced[g] = sr_q[SYNC_STAGES-1];
  end

  // Both flags set -> high, both clear -> low, anything else -> middle
  always_comb begin
    unique case ({synced[0], synced[1]})
      2'b11:   band = BAND_HIGH;
      2'b00:   band = BAND_LOW;
      default: band = BAND_MID;
    endcase
  end

  always_comb begin
    req_hs_o = (band == BAND_HIGH);
    req_ls_o = (band == BAND_LOW) || ((band == BAND_MID) && synced[2]);
  end
endmodule

// File: rtl/hb_turnon_seq.sv
module hb_turnon_seq
  import hb_pkg::*;
#(
  parameter int DELAY_CYC = 4,
  parameter int TMO_CYC   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic force_i,
  input  logic peer_cmd_i,
  input  logic peer_off_i,
  output logic gate_o,
  output logic tmo_o
);
  localparam int MAXC  = (DELAY_CYC > TMO_CYC) ? DELAY_CYC : TMO_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYC - 1);

  seq_e             state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             abort;

  assign abort = !req_i || force_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    cnt_en  = 1'b0;
    tmo_o   = 1'b0;
    unique case (state_q)
      SQ_OFF: begin
        if (!abort && !peer_cmd_i) begin
          state_d = SQ_WAIT_FB;
          cnt_en  = 1'b1;
        end
      end
      SQ_WAIT_FB: begin
        if (abort) begin
          state_d = SQ_OFF;
        end else if (peer_off_i) begin
          state_d = SQ_DELAY;
          cnt_en  = 1'b1;
        end else if (cnt_q == TMO_LAST) begin
          state_d = SQ_DELAY;
          cnt_en  = 1'b1;
          tmo_o   = 1'b1;
        end else begin
          cnt_en  = 1'b1;
          cnt_d   = cnt_q + 1'b1;
        end
      end
      SQ_DELAY: begin
        if (abort) begin
          state_d = SQ_OFF;
        end else if (peer_cmd_i) begin
          state_d = SQ_WAIT_FB;
          cnt_en  = 1'b1;
        end else if (cnt_q == DLY_LAST) begin
          state_d = SQ_ON;
        end else begin
          cnt_en  = 1'b1;
          cnt_d   = cnt_q + 1'b1;
        end
      end
      SQ_ON: begin
        if (abort) state_d = SQ_OFF;
      end
      default: state_d = SQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // force acts without waiting for an edge
  assign gate_o = (state_q == SQ_ON) && !force_i;
endmodule

// File: rtl/hb_gate_sequencer.sv
module hb_gate_sequencer #(
  parameter int DT_HS_CYC   = 4,
  parameter int DT_LS_CYC   = 4,
  parameter int FB_TMO_CYC  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_above_hi_i,
  input  logic pwm_above_lo_i,
  input  logic cur_pos_i,
  input  logic hs_off_fb_i,
  input  logic ls_off_fb_i,
  input  logic force_off_i,
  output logic hs_gate_o,
  output logic ls_gate_o,
  output logic fb_timeout_o
);
  logic rst_n_int;
  logic req_hs, req_ls;
  logic tmo_hs, tmo_ls;
  logic flag_q, flag_d, flag_en;

  hb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  hb_band_decode #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .above_hi_i (pwm_above_hi_i),
    .above_lo_i (pwm_above_lo_i),
    .cur_pos_i  (cur_pos_i),
    .req_hs_o   (req_hs),
    .req_ls_o   (req_ls)
  );

  hb_turnon_seq #(.DELAY_CYC(DT_HS_CYC), .TMO_CYC(FB_TMO_CYC)) u_hs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_i      (req_hs),
    .force_i    (force_off_i),
    .peer_cmd_i (ls_gate_o),
    .peer_off_i (ls_off_fb_i),
    .gate_o     (hs_gate_o),
    .tmo_o      (tmo_hs)
  );

  hb_turnon_seq #(.DELAY_CYC(DT_LS_CYC), .TMO_CYC(FB_TMO_CYC)) u_ls (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_i      (req_ls),
    .force_i    (force_off_i),
    .peer_cmd_i (hs_gate_o),
    .peer_off_i (hs_off_fb_i),
    .gate_o     (ls_gate_o),
    .tmo_o      (tmo_ls)
  );

  always_comb begin
    flag_en = tmo_hs || tmo_ls;
    flag_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign fb_timeout_o = flag_q;
endmodule

// File: rtl/hb_gate_sequencer_chk.sv
module hb_gate_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic force_off_i,
  input logic hs_gate_o,
  input logic ls_gate_o,
  input logic fb_timeout_o
);
  // R7
  overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate_o && ls_gate_o));

  // R8
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_off_i |-> (!hs_gate_o && !ls_gate_o));

  // R5
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_o) |-> (!$past(ls_gate_o, 1) && !$past(ls_gate_o, 2)));

  // R6
  ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate_o) |-> (!$past(hs_gate_o, 1) && !$past(hs_gate_o, 2)));

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_timeout_o |=> fb_timeout_o);
endmodule

bind hb_gate_sequencer hb_gate_sequencer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .force_off_i  (force_off_i),
  .hs_gate_o    (hs_gate_o),
  .ls_gate_o    (ls_gate_o),
  .fb_timeout_o (fb_timeout_o)
);

// File: tb/hb_gate_sequencer_bench.sv
module hb_gate_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DT_HS  = 3;
  localparam int DT_LS  = 5;
  localparam int TMO    = 20;
  localparam int SETTLE = 30;
  localparam int NV     = 12;

  // fields: {above_hi, above_lo, cur_pos, force, exp_hs, exp_ls}
  localparam logic [5:0] VEC [NV] = '{
    6'b000001, 6'b110010, 6'b011001, 6'b010000,
    6'b111010, 6'b101001, 6'b100000, 6'b001001,
    6'b110100, 6'b000100, 6'b011100, 6'b110010
  };
  string vtag [NV] = '{"R2", "R1", "R3", "R3", "R1", "R4", "R4", "R2",
                       "R8", "R8", "R8", "R1"};

  logic clk = 1'b0;
  logic rst_n;
  logic above_hi, above_lo, cur_pos, force_off;
  logic hs_fb, ls_fb, hs_gate, ls_gate, fb_tmo;
  logic stuck_hs = 1'b0, stuck_ls = 1'b0;
  int   cyc = 0, n_chk = 0, n_bad = 0, overlap_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (hs_gate && ls_gate) overlap_seen++;

  assign hs_fb = stuck_hs ? 1'b0 : !hs_gate;
  assign ls_fb = stuck_ls ? 1'b0 : !ls_gate;

  hb_gate_sequencer #(
    .DT_HS_CYC(DT_HS), .DT_LS_CYC(DT_LS), .FB_TMO_CYC(TMO), .SYNC_STAGES(2)
  ) u_hb_gate_sequencer (
    .clk(clk), .rst_n(rst_n),
    .pwm_above_hi_i(above_hi), .pwm_above_lo_i(above_lo), .cur_pos_i(cur_pos),
    .hs_off_fb_i(hs_fb), .ls_off_fb_i(ls_fb), .force_off_i(force_off),
    .hs_gate_o(hs_gate), .ls_gate_o(ls_gate), .fb_timeout_o(fb_tmo)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_band(input logic hi, input logic lo);
    above_hi = hi;
    above_lo = lo;
  endtask

  // gap in edges from the fall of 'other' to the rise of 'target'
  task automatic measure(input bit hs_target, output int gap);
    int t0;
    int lim;
    lim = 0;
    while ((hs_target ? ls_gate : hs_gate) && lim < 500) begin
      @(negedge clk); lim++;
    end
    t0 = cyc;
    while (!(hs_target ? hs_gate : ls_gate) && lim < 500) begin
      @(negedge clk); lim++;
    end
    gap = cyc - t0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int gap;
    rst_n = 1'b0; above_hi = 1'b0; above_lo = 1'b0; cur_pos = 1'b0; force_off = 1'b0;
    settle(3);
    chk("R10", "reset hs", int'(hs_gate), 0);
    chk("R10", "reset ls", int'(ls_gate), 0);
    chk("R10", "reset flag", int'(fb_tmo), 0);
    rst_n = 1'b1;
    settle(SETTLE);

    for (int i = 0; i < NV; i++) begin
      above_hi  = VEC[i][5];
      above_lo  = VEC[i][4];
      cur_pos   = VEC[i][3];
      force_off = VEC[i][2];
      settle(SETTLE);
      chk(vtag[i], $sformatf("vec%0d hs", i), int'(hs_gate), int'(VEC[i][1]));
      chk(vtag[i], $sformatf("vec%0d ls", i), int'(ls_gate), int'(VEC[i][0]));
    end
    force_off = 1'b0;

    // R5 high-side turn-on gap
    set_band(1'b0, 1'b0); settle(SETTLE);
    set_band(1'b1, 1'b1);
    measure(1'b1, gap);
    chk("R5", "hs turn-on gap", gap, 2 + DT_HS);

    // R6 low-side turn-on gap
    settle(SETTLE);
    set_band(1'b0, 1'b0);
    measure(1'b0, gap);
    chk("R6", "ls turn-on gap", gap, 2 + DT_LS);

    // R8 force acts within the cycle
    settle(SETTLE);
    chk("R8", "ls on before force", int'(ls_gate), 1);
    force_off = 1'b1;
    #1;
    chk("R8", "ls low same cycle", int'(ls_gate), 0);
    settle(1);
    force_off = 1'b0;
    settle(SETTLE);
    chk("R8", "ls back after release", int'(ls_gate), 1);

    // R9 stuck low-side feedback
    chk("R9", "flag before timeout", int'(fb_tmo), 0);
    stuck_ls = 1'b1;
    set_band(1'b1, 1'b1);
    measure(1'b1, gap);
    chk("R9", "hs gap after timeout", gap, 1 + TMO + DT_HS);
    chk("R9", "flag after timeout", int'(fb_tmo), 1);

    // R10 flag is sticky
    stuck_ls = 1'b0;
    settle(SETTLE);
    set_band(1'b0, 1'b0); settle(SETTLE);
    set_band(1'b0, 1'b1); cur_pos = 1'b1; settle(SETTLE);
    chk("R10", "flag still set", int'(fb_tmo), 1);
    chk("R3", "mid positive ls", int'(ls_gate), 1);

    // R10 asynchronous reset clears everything
    rst_n = 1'b0;
    #1;
    chk("R10", "reset clears flag", int'(fb_tmo), 0);
    chk("R10", "reset clears ls", int'(ls_gate), 0);
    settle(2);
    rst_n = 1'b1;
    settle(SETTLE);

    chk("R7", "overlap cycles", overlap_seen, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule